// File: doc/BRIEF.md
# Configurable Separable Block Transform

This block computes the forward residual transforms of a video encoder, one block at a time. Rows of signed 16-bit residual samples arrive one per beat. Each accepted row goes through a 1D transform at once, and the intermediate row is stored in an internal transpose buffer. When the whole block is in, the block reads the buffer column by column. It applies the same 1D transform to each column and emits one result row per beat.

A two-bit mode input selects the transform for a block:

- the 4x4 integer core transform,
- the 4x4 Hadamard transform used on luma DC terms, or
- the 2x2 Hadamard transform used on chroma DC terms.

The mode is sampled with the first row of each block. Both the input and the output use valid/ready handshakes. A stalled output holds the block, and new input is refused until every result row of the current block has been loaded into the output register. Gathering DC terms from several blocks is left to the surrounding logic, and so are buffer addressing and quantization.

Top module: `sep_block_xform`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. A reset in the middle of a block discards the partial block, and the next row accepted is treated as row 0 of a new block.
- R2: Lane k of in_row and out_row occupies bits [16k+15:16k] as a two's-complement value. cfg_mode encodings:
  - 0 selects the core transform,
  - 1 selects the 4x4 Hadamard transform,
  - 2 selects the 2x2 Hadamard transform,
  - 3 behaves as 0.
- R3: In core mode, with input rows X and kernel C = [1 1 1 1; 2 1 -1 -2; 1 -1 -1 1; 1 -2 2 -1], define M[r][c] = sum_k C[c][k]·X[r][k]. Output row j lane i is then sum_r C[i][r]·M[r][j].
- R4: In 4x4 Hadamard mode, the same structure is used with H = [1 1 1 1; 1 1 -1 -1; 1 -1 -1 1; 1 -1 1 -1]. Each final value v is then replaced by (v+1)>>1, an arithmetic shift, so v=+1 gives 1, v=-1 gives 0 and v=-3 gives -1.
- R5: In 2x2 Hadamard mode, the kernel [1 1; 1 -1] is applied with no scaling. Only two input rows and two output rows make a block. Input lanes 2 and 3 are ignored, and output lanes 2 and 3 are zero.
- R6: From the acceptance of the last input row until the last result row has been loaded into the output register, in_ready is 0. Afterwards in_ready is 1 again.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_row stay unchanged.
- R8: cfg_mode is sampled only when the first row of a block is accepted. Changes during the rest of the block have no effect on its results.
- R9: Outputs are the low 16 bits of the results. Results are exact whenever the input residuals lie within 9-bit signed range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Transform select, sampled on the first row of a block |
| in_valid | input | 1 | Input row is valid |
| in_ready | output | 1 | Block can accept an input row |
| in_row | input | 64 | Four 16-bit residual lanes |
| out_valid | output | 1 | Output row is valid |
| out_ready | input | 1 | Downstream accepts the output row |
| out_row | output | 64 | Four 16-bit coefficient lanes |

## Verification
The overflow assertion assumes that every result fits in 16 bits, which holds only when residuals stay within 9-bit signed range. The stimulus therefore draws every random residual from [-256, 255] and uses small constants in the directed cases. The handshake assertions also assume that in_valid and in_row are held until in_ready accepts them. The bench drivers keep to that rule, and they stall out_ready for several cycles so that the hold and blocking properties are actually exercised.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam logic [1:0] XF_CORE = 2'd0;
  localparam logic [1:0] XF_HAD4 = 2'd1;
  localparam logic [1:0] XF_HAD2 = 2'd2;
  localparam int         XF_LANES = 4;
  localparam int         XF_GROW  = 3;  // bits of growth per 1D pass
endpackage

// File: rtl/xf_kernel.sv
module xf_kernel
  import sbx_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = IW + XF_GROW
) (
  input  logic [1:0]                   mode,
  input  logic [XF_LANES-1:0][IW-1:0]  x,
  output logic [XF_LANES-1:0][OW-1:0]  y
);
  localparam int EXT = OW - IW;

  logic signed [OW-1:0] xe [XF_LANES];

  for (genvar g = 0; g < XF_LANES; g++) begin : g_ext
    assign xe[g] = {{EXT{x[g][IW-1]}}, x[g]};
  end

  logic signed [OW-1:0] s03, d03, s12, d12, s01, d01;

  always_comb begin
    // butterflies shared by all three kernels
    s03 = xe[0] + xe[3];
    d03 = xe[0] - xe[3];
    s12 = xe[1] + xe[2];
    d12 = xe[1] - xe[2];
    s01 = xe[0] + xe[1];
    d01 = xe[0] - xe[1];
    case (mode)
      XF_HAD4: begin
        y[0] = s03 + s12;
        y[1] = d03 + d12;
        y[2] = s03 - s12;
        y[3] = d03 - d12;
      end
      XF_HAD2: begin
        y[0] = s01;
        y[1] = d01;
        y[2] = '0;
        y[3] = '0;
      end
      default: begin
        y[0] = s03 + s12;
        y[1] = (d03 <<< 1) + d12;
        y[2] = s03 - s12;
        y[3] = d03 - (d12 <<< 1);
      end
    endcase
  end
endmodule

// File: rtl/xf_tbuf.sv
module xf_tbuf
  import sbx_pkg::*;
#(
  parameter int W = 19
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_idx,
  input  logic [XF_LANES-1:0][W-1:0]  wr_data,
  input  logic [1:0]                  rd_idx,
  output logic [XF_LANES-1:0][W-1:0]  rd_data
);
  logic [W-1:0] mem [XF_LANES][XF_LANES];

  // row-wise write
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < XF_LANES; c++) mem[wr_idx][c] <= wr_data[c];
    end
  end

  // column-wise read gives the transposed row
  always_comb begin
    for (int r = 0; r < XF_LANES; r++) rd_data[r] = mem[r][rd_idx];
  end
endmodule

// File: rtl/xf_scale.sv
module xf_scale
  import sbx_pkg::*;
#(
  parameter int IW = 22,
  parameter int OW = 16
) (
  input  logic [1:0]                   mode,
  input  logic [XF_LANES-1:0][IW-1:0]  x,
  output logic [XF_LANES-1:0][OW-1:0]  y,
  output logic                         fits
);
  localparam logic signed [IW-1:0] ONE = 1;

  logic [XF_LANES-1:0] lane_ok;

  for (genvar g = 0; g < XF_LANES; g++) begin : g_lane
    logic signed [IW-1:0] v, r;
    assign v = x[g];
    assign r = (mode == XF_HAD4) ? ((v + ONE) >>> 1) : v;
    assign y[g] = r[OW-1:0];
    assign lane_ok[g] = (&r[IW-1:OW-1]) | ~(|r[IW-1:OW-1]);
  end

  assign fits = &lane_ok;
endmodule

// File: rtl/sep_block_xform.sv
module sep_block_xform
  import sbx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cfg_mode,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [XF_LANES*DW-1:0]  in_row,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [XF_LANES*DW-1:0]  out_row
);
  localparam int MW = DW + XF_GROW;  // after row pass
  localparam int FW = MW + XF_GROW;  // after column pass

  logic       out_phase;
  logic [1:0] cnt;
  logic [1:0] mode_q;
  logic [1:0] act_mode;
  logic [1:0] in_last, out_last;
  logic       in_fire, out_fire;

  logic [XF_LANES-1:0][DW-1:0] row_in;
  logic [XF_LANES-1:0][MW-1:0] row_mid;
  logic [XF_LANES-1:0][MW-1:0] col_mid;
  logic [XF_LANES-1:0][FW-1:0] col_out;
  logic [XF_LANES-1:0][DW-1:0] scaled;
  logic                        fits;

  assign row_in   = in_row;
  assign act_mode = (!out_phase && cnt == 2'd0) ? cfg_mode : mode_q;
  assign in_last  = (act_mode == XF_HAD2) ? 2'd1 : 2'd3;
  assign out_last = (mode_q == XF_HAD2) ? 2'd1 : 2'd3;
  assign in_ready = !out_phase;
  assign in_fire  = in_valid && !out_phase;
  assign out_fire = out_phase && (!out_valid || out_ready);

  xf_kernel #(.IW(DW), .OW(MW)) u_row (
    .mode (act_mode),
    .x    (row_in),
    .y    (row_mid)
  );

  xf_tbuf #(.W(MW)) u_buf (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_idx  (cnt),
    .wr_data (row_mid),
    .rd_idx  (cnt),
    .rd_data (col_mid)
  );

  xf_kernel #(.IW(MW), .OW(FW)) u_col (
    .mode (mode_q),
    .x    (col_mid),
    .y    (col_out)
  );

  xf_scale #(.IW(FW), .OW(DW)) u_scl (
    .mode (mode_q),
    .x    (col_out),
    .y    (scaled),
    .fits (fits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_phase <= 1'b0;
      cnt       <= 2'd0;
      mode_q    <= XF_CORE;
      out_valid <= 1'b0;
      out_row   <= '0;
    end else begin
      if (in_fire) begin
        if (cnt == 2'd0) mode_q <= cfg_mode;
        if (cnt == in_last) begin
          out_phase <= 1'b1;
          cnt       <= 2'd0;
        end else begin
          cnt <= cnt + 2'd1;
        end
      end
      if (out_fire) begin
        out_row   <= scaled;
        out_valid <= 1'b1;
        if (cnt == out_last) begin
          out_phase <= 1'b0;
          cnt       <= 2'd0;
        end else begin
          cnt <= cnt + 2'd1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: stalled output is held
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_row));

  // R6: last input row closes the input side
  assert_in_block_R6: assert property (@(posedge clk) disable iff (rst)
    in_fire && cnt == in_last |=> !in_ready);

  // R6: last result row reopens the input side
  assert_in_release_R6: assert property (@(posedge clk) disable iff (rst)
    out_fire && cnt == out_last |=> in_ready);

  // R5: unused lanes are zero in 2x2 mode
  assert_zero_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    out_fire && mode_q == XF_HAD2 |=> out_row[XF_LANES*DW-1:2*DW] == '0);

  // R8: mode cannot move inside a block
  assert_mode_latched_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt != 2'd0 || out_phase) |=> $stable(mode_q));

  // R9: results fit the output width for bounded residuals
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    out_fire |-> fits);
endmodule

// File: tb/sim_sep_block_xform.sv
module sim_sep_block_xform;
  localparam int CLK_NS = 10;
  localparam int NV = 9;
  localparam int TV_MODE  [NV] = '{0, 1, 2, 0, 1, 2, 3, 0, 2};
  localparam int TV_STALL [NV] = '{0, 0, 0, 2, 3, 1, 0, 1, 2};
  localparam int CORE_C [4][4] = '{'{1, 1, 1, 1}, '{2, 1, -1, -2},
                                   '{1, -1, -1, 1}, '{1, -2, 2, -1}};
  localparam int HAD_C  [4][4] = '{'{1, 1, 1, 1}, '{1, 1, -1, -1},
                                   '{1, -1, -1, 1}, '{1, -1, 1, -1}};

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_mode;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_row, out_row;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int unsigned rng = 32'h1ACE_5EED;
  int xm [4][4];
  int zm [4][4];
  int got [4][4];

  always #(CLK_NS/2) clk = ~clk;

  sep_block_xform u0 (
    .clk (clk), .rst (rst), .cfg_mode (cfg_mode),
    .in_valid (in_valid), .in_ready (in_ready), .in_row (in_row),
    .out_valid (out_valid), .out_ready (out_ready), .out_row (out_row)
  );

  function automatic int coef(int m, int i, int k);
    if (m == 1) return HAD_C[i][k];
    if (m == 2) return (i < 2 && k < 2) ? ((i == 1 && k == 1) ? -1 : 1) : 0;
    return CORE_C[i][k];
  endfunction

  function automatic int rnd9();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return int'(rng % 512) - 256;
  endfunction

  task automatic compute_ref(int m);
    int mid [4][4];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        mid[r][c] = 0;
        for (int k = 0; k < 4; k++) mid[r][c] += coef(m, c, k) * xm[r][k];
      end
    for (int j = 0; j < 4; j++)
      for (int i = 0; i < 4; i++) begin
        int s = 0;
        for (int r = 0; r < 4; r++) s += coef(m, i, r) * mid[r][j];
        zm[j][i] = (m == 1) ? ((s + 1) >>> 1) : s;
      end
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_row(logic [63:0] r);
    @(negedge clk);
    in_valid = 1'b1;
    in_row = r;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic get_row(int stall, string req, output logic [63:0] r);
    @(negedge clk);
    out_ready = 1'b0;
    while (!out_valid) @(negedge clk);
    r = out_row;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_row == r, "R7 hold", out_row, r);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  task automatic run_block(int m, int m_late, int stall, string req);
    int n = (m == 2) ? 2 : 4;
    logic [63:0] r, e;
    compute_ref(m);
    for (int row = 0; row < n; row++) begin
      for (int k = 0; k < 4; k++) r[16*k +: 16] = 16'(xm[row][k]);
      cfg_mode = 2'((row == 0) ? m : m_late);
      put_row(r);
    end
    @(negedge clk);
    chk(!in_ready, "R6 busy", 64'(in_ready), 64'd0);
    for (int j = 0; j < n; j++) begin
      get_row(stall, req, r);
      for (int i = 0; i < 4; i++) begin
        e[16*i +: 16] = 16'(zm[j][i]);
        got[j][i] = int'($signed(r[16*i +: 16]));
      end
      chk(r == e, req, r, e);
    end
    @(negedge clk);
    chk(in_ready, "R6 release", 64'(in_ready), 64'd1);
  endtask

  task automatic fill_rand();
    for (int r = 0; r < 4; r++) for (int k = 0; k < 4; k++) xm[r][k] = rnd9();
  endtask

  task automatic fill_const(int v);
    for (int r = 0; r < 4; r++) for (int k = 0; k < 4; k++) xm[r][k] = v;
  endtask

  task automatic fill_point(int v);
    fill_const(0);
    xm[0][0] = v;
  endtask

  initial begin
    rst = 1'b1; cfg_mode = 2'd0; in_valid = 1'b0; in_row = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset",
        {62'd0, in_ready, out_valid}, 64'h2);

    // table walk: random 9-bit residuals in every mode (R2 R3 R4 R5 R9)
    for (int t = 0; t < NV; t++) begin
      fill_rand();
      run_block(TV_MODE[t], TV_MODE[t], TV_STALL[t],
                TV_MODE[t] == 1 ? "R4 table" : (TV_MODE[t] == 2 ? "R5 table" : "R3 R9 table"));
    end

    // R3: constant block gives only a DC term of 16
    fill_const(1);
    run_block(0, 0, 0, "R3 const");
    chk(got[0][0] == 16 && got[1][1] == 0, "R3 dc", 64'(got[0][0]), 64'd16);

    // R4: rounding of positive and negative points
    fill_point(1);
    run_block(1, 1, 0, "R4 +1");
    chk(got[3][3] == 1, "R4 round +1", 64'(got[3][3]), 64'd1);
    fill_point(-1);
    run_block(1, 1, 0, "R4 -1");
    chk(got[2][1] == 0, "R4 round -1", 64'(got[2][1]), 64'd0);
    fill_point(-3);
    run_block(1, 1, 1, "R4 -3");
    chk(got[1][2] == -1, "R4 round -3", 64'(got[1][2]), 64'hFFFF_FFFF_FFFF_FFFF);

    // R5: 2x2 with junk in ignored lanes, constant ones
    fill_const(1);
    xm[0][2] = 200; xm[1][3] = -77;
    run_block(2, 2, 0, "R5 junk lanes");
    chk(got[0][0] == 4 && got[0][2] == 0, "R5 dc", 64'(got[0][0]), 64'd4);

    // R8: mode changed after first row has no effect
    fill_rand();
    run_block(1, 0, 0, "R8 late mode");
    fill_rand();
    run_block(2, 0, 0, "R8 late mode 2x2");

    // R1: reset in mid-block discards partial rows
    fill_const(5);
    cfg_mode = 2'd0;
    put_row(64'h0005_0005_0005_0005);
    put_row(64'h0005_0005_0005_0005);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 mid reset",
        {62'd0, in_ready, out_valid}, 64'h2);
    run_block(0, 0, 0, "R1 after reset");
    chk(got[0][0] == 80, "R1 fresh block", 64'(got[0][0]), 64'd80);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule